// File: doc/BRIEF.md
# SPI Command Stream Sequencer

This block is an SPI master that runs a program rather than being driven byte by byte. Each 16-bit command word carries a 4-bit opcode in bits [15:12], a 4-bit first argument in bits [11:8] and an 8-bit second argument in bits [7:0]. The command set has five actions. One moves a run of bytes. One sets the eight chip-select lines. One loads one of the internal setup registers. One waits for a number of SCLK periods. One announces that the program has reached a marker.

Command words arrive on a valid/ready stream from an external command FIFO. Bytes to send come from an external transmit FIFO on another valid/ready stream. Received bytes are pushed into an external receive FIFO as one-cycle valid pulses, gated by that FIFO's not-full flag. A host fills the command FIFO with a program that ends in a sync marker. It then watches for the sync pulse and identifier to learn that the program has finished.

Top module: `spi_cmd_seq`

## Requirements
- R1: After a synchronous reset, the outputs are: cs_n = 8'hFF, sclk = 0, sync_pulse = 0, sync_id = 0, three_wire = 0, sdo_oe = 1 and cmd_ready = 1.
- R2: Opcode 0 with second argument N moves N+1 bytes. If first-argument bit 0 is set, each byte is taken from the transmit stream in arrival order and shifted out on sdo MSB first.
- R3: During opcode 0, if first-argument bit 1 is set, each byte sampled on sdi (MSB first) is pushed with one sdi_valid pulse. If that bit is clear, nothing is pushed.
- R4: Opcode 2 with first argument 1 loads the mode bits from the second argument: bit 1 is the SCLK idle level, and bit 0 set moves sampling to the trailing edge (shifting on the leading edge). With bit 0 clear, sampling is on the leading edge.
- R5: Opcode 2 with first argument 0 loads the divider D. Each SCLK half period then lasts D+1 clock cycles, so a byte holds SCLK at its active level for 8*(D+1) cycles.
- R6: Opcode 1 puts its second argument on cs_n in the cycle after it is accepted. The next command is then refused for A*(D+1) cycles, where A is the first argument.
- R7: Opcode 3 with first argument 1 and second argument S refuses the next command for 2*(S+1)*(D+1) cycles.
- R8: Opcode 3 with first argument 0 raises sync_pulse for exactly the cycle after acceptance, with sync_id holding the second argument from that cycle on.
- R9: A transfer that sends bytes makes no SCLK edge while the transmit stream has no byte. It resumes when a byte arrives.
- R10: A transfer that reads bytes makes no SCLK edge while sdi_ready is low. It resumes when room appears.
- R11: Mode bit 2 drives three_wire. In three-wire mode, sdo_oe is low throughout a read-only transfer and stays high for transfers that send.
- R12: A register write whose first argument is neither 0 nor 1, or an opcode above 3, changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command word available |
| cmd_ready | output | 1 | Sequencer takes a command this cycle |
| cmd_data | input | 16 | Command word |
| sdo_valid | input | 1 | Transmit byte available |
| sdo_ready | output | 1 | Transmit byte consumed this cycle |
| sdo_data | input | 8 | Transmit byte |
| sdi_ready | input | 1 | Receive FIFO has room |
| sdi_valid | output | 1 | Received byte push strobe |
| sdi_data | output | 8 | Received byte |
| sclk | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for sdo |
| sdi | input | 1 | Serial data in (shared line in three-wire mode) |
| three_wire | output | 1 | Three-wire mode indicator |
| cs_n | output | 8 | Active-low chip selects |
| sync_pulse | output | 1 | Sync marker reached |
| sync_id | output | 8 | Identifier of the last sync marker |

## Verification
Changes to cs_n, sync_pulse and sync_id show up at the first falling clock edge after the rising edge that accepts the command. The bench reads them at exactly that point, and reads sync_pulse again one falling edge later to confirm it has dropped. For waits, the bench counts the falling edges on which cmd_ready stays low after acceptance and compares that count with the exact product 2*(S+1)*(D+1) or A*(D+1).

Serial results have no fixed latency. A bench slave therefore records bits on the SCLK edges that the mode calls for. It also counts cycles spent at the active SCLK level, and those counts are compared only after the sequencer has gone idle. Stall checks hold the stream empty or full for 20 cycles and confirm that no SCLK edge appeared in that time.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;
  localparam int CMD_W = 16;

  typedef enum logic [3:0] {
    OP_XFER  = 4'd0,
    OP_CS    = 4'd1,
    OP_WRREG = 4'd2,
    OP_MISC  = 4'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_SHIFT,
    ST_WAIT
  } st_e;

  typedef struct packed {
    logic [3:0] op;
    logic [3:0] a1;
    logic [7:0] a2;
  } cmd_t;

  localparam logic [3:0] REG_DIV    = 4'd0;
  localparam logic [3:0] REG_MODE   = 4'd1;
  localparam logic [3:0] MISC_SYNC  = 4'd0;
  localparam logic [3:0] MISC_SLEEP = 4'd1;
endpackage

// File: rtl/spi_seq_tick.sv
module spi_seq_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = en && (cnt_q == div);

  always_ff @(posedge clk) begin
    if (rst || !en) cnt_q <= '0;
    else if (tick)  cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_seq_shift.sv
module spi_seq_shift #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic          tick,
  input  logic          cpha,
  input  logic          sdi_in,
  output logic          sdo_bit,
  output logic          phase,
  output logic          done,
  output logic [DW-1:0] rx_byte
);
  localparam int EW = $clog2(2 * DW);
  localparam logic [EW-1:0] LAST_EDGE = EW'(2 * DW - 1);

  logic [DW-1:0] tx_q, rx_q;
  logic [EW-1:0] edge_q;
  logic          lead, do_sample, do_shift;

  assign lead      = ~edge_q[0];
  assign do_sample = tick && (lead ^ cpha);
  assign do_shift  = tick && (cpha ? (lead && edge_q != '0) : !lead);
  assign done      = tick && (edge_q == LAST_EDGE);
  assign sdo_bit   = tx_q[DW-1];
  assign rx_byte   = cpha ? {rx_q[DW-2:0], sdi_in} : rx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q   <= '0;
      rx_q   <= '0;
      edge_q <= '0;
      phase  <= 1'b0;
    end else if (load) begin
      tx_q   <= load_data;
      edge_q <= '0;
      phase  <= 1'b0;
    end else if (tick) begin
      phase  <= ~phase;
      edge_q <= edge_q + 1'b1;
      if (do_sample) rx_q <= {rx_q[DW-2:0], sdi_in};
      if (do_shift)  tx_q <= {tx_q[DW-2:0], 1'b0};
    end
  end

  a_r2_shift_idle: assert property (@(posedge clk) disable iff (rst)
    load |=> (phase == 1'b0));
endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
  import spi_seq_pkg::*;
#(
  parameter int DW    = 8,
  parameter int CS_W  = 8,
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [CMD_W-1:0]  cmd_data,
  input  logic              sdo_valid,
  output logic              sdo_ready,
  input  logic [DW-1:0]     sdo_data,
  input  logic              sdi_ready,
  output logic              sdi_valid,
  output logic [DW-1:0]     sdi_data,
  output logic              sclk,
  output logic              sdo,
  output logic              sdo_oe,
  input  logic              sdi,
  output logic              three_wire,
  output logic [CS_W-1:0]   cs_n,
  output logic              sync_pulse,
  output logic [7:0]        sync_id
);
  localparam int WAIT_W = 10;

  st_e              state_q;
  cmd_t             cmd;
  logic [DIV_W-1:0] div_q;
  logic [2:0]       mode_q;
  logic             wr_q, rd_q;
  logic [7:0]       left_q;
  logic [WAIT_W-1:0] wait_q;
  logic             accept, go_load, tick, sh_tick, sh_done, phase;
  logic [DW-1:0]    rx_byte;

  assign cmd        = cmd_t'(cmd_data);
  assign cmd_ready  = (state_q == ST_IDLE);
  assign accept     = cmd_valid && cmd_ready;
  assign go_load    = (state_q == ST_LOAD) && (!wr_q || sdo_valid) && (!rd_q || sdi_ready);
  assign sdo_ready  = go_load && wr_q;
  assign sh_tick    = tick && (state_q == ST_SHIFT);
  assign sclk       = phase ^ mode_q[1];
  assign three_wire = mode_q[2];
  assign sdo_oe     = ~(mode_q[2] && !wr_q && (state_q == ST_LOAD || state_q == ST_SHIFT));

  spi_seq_tick #(.DIV_W(DIV_W)) tick_i (
    .clk (clk),
    .rst (rst),
    .en  (state_q == ST_SHIFT || state_q == ST_WAIT),
    .div (div_q),
    .tick(tick)
  );

  spi_seq_shift #(.DW(DW)) shift_i (
    .clk      (clk),
    .rst      (rst),
    .load     (go_load),
    .load_data(wr_q ? sdo_data : '0),
    .tick     (sh_tick),
    .cpha     (mode_q[0]),
    .sdi_in   (sdi),
    .sdo_bit  (sdo),
    .phase    (phase),
    .done     (sh_done),
    .rx_byte  (rx_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      div_q      <= '0;
      mode_q     <= '0;
      wr_q       <= 1'b0;
      rd_q       <= 1'b0;
      left_q     <= '0;
      wait_q     <= '0;
      cs_n       <= '1;
      sync_pulse <= 1'b0;
      sync_id    <= '0;
      sdi_valid  <= 1'b0;
      sdi_data   <= '0;
    end else begin
      sync_pulse <= 1'b0;
      sdi_valid  <= 1'b0;
      case (state_q)
        ST_IDLE: if (accept) begin
          case (cmd.op)
            OP_XFER: begin
              wr_q    <= cmd.a1[0];
              rd_q    <= cmd.a1[1];
              left_q  <= cmd.a2;
              state_q <= ST_LOAD;
            end
            OP_CS: begin
              cs_n <= CS_W'(cmd.a2);
              if (cmd.a1 != 4'd0) begin
                wait_q  <= WAIT_W'(cmd.a1);
                state_q <= ST_WAIT;
              end
            end
            OP_WRREG: begin
              if (cmd.a1 == REG_DIV)  div_q  <= DIV_W'(cmd.a2);
              if (cmd.a1 == REG_MODE) mode_q <= cmd.a2[2:0];
            end
            OP_MISC: begin
              if (cmd.a1 == MISC_SYNC) begin
                sync_pulse <= 1'b1;
                sync_id    <= cmd.a2;
              end
              if (cmd.a1 == MISC_SLEEP) begin
                wait_q  <= (WAIT_W'(cmd.a2) + 1'b1) << 1;
                state_q <= ST_WAIT;
              end
            end
            default: ;
          endcase
        end
        ST_LOAD: if (go_load) state_q <= ST_SHIFT;
        ST_SHIFT: if (sh_done) begin
          sdi_valid <= rd_q;
          sdi_data  <= rx_byte;
          if (left_q == 8'd0) state_q <= ST_IDLE;
          else begin
            left_q  <= left_q - 1'b1;
            state_q <= ST_LOAD;
          end
        end
        ST_WAIT: if (tick) begin
          if (wait_q == WAIT_W'(1)) state_q <= ST_IDLE;
          else                      wait_q  <= wait_q - 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  a_r8_sync_after_accept: assert property (@(posedge clk) disable iff (rst)
    sync_pulse |-> $past(cmd_valid && cmd_ready));
  a_r6_cs_only_on_command: assert property (@(posedge clk) disable iff (rst)
    !$stable(cs_n) |-> $past(cmd_valid && cmd_ready));
  a_r9_no_sdo_underflow: assert property (@(posedge clk) disable iff (rst)
    sdo_ready |-> sdo_valid);
  a_r4_sclk_idle_level: assert property (@(posedge clk) disable iff (rst)
    cmd_ready |-> (sclk == mode_q[1]));
  a_r11_oe_only_three_wire: assert property (@(posedge clk) disable iff (rst)
    !sdo_oe |-> three_wire);
endmodule

// File: tb/spi_cmd_seq_tb_top.sv
module spi_cmd_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [15:0] cmd_data = '0;
  logic        sdo_valid, sdo_ready;
  logic [7:0]  sdo_data;
  logic        sdi_ready = 1'b1;
  logic        sdi_valid;
  logic [7:0]  sdi_data;
  logic        sclk, sdo, sdo_oe, sdi, three_wire, sync_pulse;
  logic [7:0]  cs_n, sync_id;

  always #5 clk = ~clk;

  spi_cmd_seq dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
    .sdo_valid(sdo_valid), .sdo_ready(sdo_ready), .sdo_data(sdo_data),
    .sdi_ready(sdi_ready), .sdi_valid(sdi_valid), .sdi_data(sdi_data),
    .sclk(sclk), .sdo(sdo), .sdo_oe(sdo_oe), .sdi(sdi), .three_wire(three_wire),
    .cs_n(cs_n), .sync_pulse(sync_pulse), .sync_id(sync_id)
  );

  // transmit FIFO model
  logic [7:0] sdo_mem [0:15];
  int sdo_wr = 0, sdo_rd = 0;
  assign sdo_valid = (sdo_rd < sdo_wr);
  assign sdo_data  = sdo_mem[sdo_rd[3:0]];
  always @(posedge clk) if (sdo_ready && sdo_valid) sdo_rd <= sdo_rd + 1;

  // receive FIFO model
  logic [7:0] rx_mem [0:15];
  int rx_n = 0;
  always @(posedge clk) if (sdi_valid) begin
    rx_mem[rx_n[3:0]] <= sdi_data;
    rx_n <= rx_n + 1;
  end

  // SPI slave model
  logic [2:0] cur_mode = 3'd0;
  logic [7:0] miso_byte = 8'h00;
  logic [7:0] mosi_sh = 8'h00;
  logic [7:0] got [0:15];
  int gn = 0, scnt = 0, edges = 0, hi_cyc = 0, oe_low = 0;
  logic prev_sclk = 1'b0;
  assign sdi = miso_byte[3'(7 - scnt)];

  always @(negedge clk) begin
    if (cs_n == 8'hFF) scnt <= 0;
    else begin
      if (sclk != cur_mode[1]) hi_cyc <= hi_cyc + 1;
      if (!sdo_oe) oe_low <= oe_low + 1;
      if (sclk != prev_sclk) begin
        edges <= edges + 1;
        if ((sclk != cur_mode[1]) ^ cur_mode[0]) begin
          mosi_sh <= {mosi_sh[6:0], sdo};
          if (scnt == 7) begin
            got[gn[3:0]] <= {mosi_sh[6:0], sdo};
            gn <= gn + 1;
            scnt <= 0;
          end else scnt <= scnt + 1;
        end
      end
    end
    prev_sclk <= sclk;
  end

  int nchk = 0, nfail = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] c, output int busy);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_data  = c;
    while (!cmd_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    busy = 0;
    while (!cmd_ready) begin
      busy++;
      @(negedge clk);
    end
  endtask

  task automatic push_tx(input logic [7:0] b);
    sdo_mem[sdo_wr[3:0]] = b;
    sdo_wr++;
  endtask

  // {mode, divider, tx byte, miso byte}
  localparam logic [31:0] VEC [6] = '{
    32'h00_00_A5_3C, 32'h01_01_96_E1, 32'h02_02_5A_0F,
    32'h03_00_C3_81, 32'h00_03_01_80, 32'h03_02_7E_FF
  };

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    int b, g0, r0, h0, e0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(cs_n == 8'hFF && sclk == 1'b0 && sync_pulse == 1'b0, "R1 cs/sclk/sync", {cs_n, 7'd0, sclk, 7'd0, sync_pulse}, 32'hFF_00_00);
    chk(sync_id == 8'h00 && three_wire == 1'b0 && sdo_oe && cmd_ready, "R1 id/3w/oe/ready",
        {sync_id, three_wire, sdo_oe, cmd_ready}, {8'h00, 3'b011});

    // vector table: modes and dividers (R2 R3 R4 R5 R8)
    for (int i = 0; i < 6; i++) begin
      cur_mode = VEC[i][26:24];
      send(16'h2100 | {8'h00, VEC[i][31:24]}, b);
      send(16'h2000 | {8'h00, VEC[i][23:16]}, b);
      send(16'h10FE, b);
      push_tx(VEC[i][15:8]);
      miso_byte = VEC[i][7:0];
      g0 = gn; r0 = rx_n; h0 = hi_cyc;
      send(16'h0300, b);
      @(negedge clk);
      chk(got[g0[3:0]] == VEC[i][15:8], "R2 R4 mosi byte", got[g0[3:0]], VEC[i][15:8]);
      chk(rx_n == r0 + 1 && rx_mem[r0[3:0]] == VEC[i][7:0], "R3 R4 miso byte", rx_mem[r0[3:0]], VEC[i][7:0]);
      chk(hi_cyc - h0 == 8 * (VEC[i][23:16] + 1), "R5 active sclk cycles", hi_cyc - h0, 8 * (VEC[i][23:16] + 1));
      chk(sclk == VEC[i][25], "R4 sclk idle level", sclk, VEC[i][25]);
      send(16'h10FF, b);
      send(16'h3000 | 16'(i + 1), b);
      chk(sync_pulse && sync_id == 8'(i + 1), "R8 sync id", {sync_pulse, sync_id}, {1'b1, 8'(i + 1)});
      @(negedge clk);
      chk(!sync_pulse, "R8 single pulse", sync_pulse, 0);
    end

    // R2 multi-byte write-only, R3 nothing pushed
    cur_mode = 3'd0;
    send(16'h2100, b); send(16'h2000, b); send(16'h10FE, b);
    push_tx(8'h11); push_tx(8'h22); push_tx(8'h33);
    g0 = gn; r0 = rx_n;
    send(16'h0102, b);
    @(negedge clk);
    chk(gn == g0 + 3 && got[g0[3:0]] == 8'h11 && got[4'(g0 + 1)] == 8'h22 && got[4'(g0 + 2)] == 8'h33,
        "R2 three bytes in order", {got[g0[3:0]], got[4'(g0 + 1)], got[4'(g0 + 2)]}, 24'h112233);
    chk(rx_n == r0, "R3 no push without read flag", rx_n - r0, 0);

    // R6 chip-select delay, R7 sleep
    send(16'h2001, b);
    send(16'h13FD, b);
    chk(b == 6, "R6 cs delay cycles", b, 6);
    chk(cs_n == 8'hFD, "R6 cs pattern", cs_n, 8'hFD);
    send(16'h2002, b);
    send(16'h3101, b);
    chk(b == 12, "R7 sleep cycles", b, 12);
    send(16'h2000, b);
    send(16'h3100, b);
    chk(b == 2, "R7 shortest sleep", b, 2);

    // R9 transmit stall
    send(16'h10FE, b);
    @(negedge clk); cmd_valid = 1'b1; cmd_data = 16'h0100;
    @(negedge clk); cmd_valid = 1'b0;
    e0 = edges; g0 = gn;
    repeat (20) @(negedge clk);
    chk(edges == e0 && !cmd_ready, "R9 stalled without sdo byte", edges - e0, 0);
    push_tx(8'h5C);
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    chk(got[g0[3:0]] == 8'h5C, "R9 resumed byte", got[g0[3:0]], 8'h5C);

    // R10 receive stall
    sdi_ready = 1'b0; miso_byte = 8'hB4; r0 = rx_n;
    @(negedge clk); cmd_valid = 1'b1; cmd_data = 16'h0200;
    @(negedge clk); cmd_valid = 1'b0;
    e0 = edges;
    repeat (20) @(negedge clk);
    chk(edges == e0 && !cmd_ready, "R10 stalled while full", edges - e0, 0);
    sdi_ready = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    chk(rx_mem[r0[3:0]] == 8'hB4, "R10 resumed byte", rx_mem[r0[3:0]], 8'hB4);

    // R11 three-wire
    send(16'h10FF, b);
    cur_mode = 3'd4;
    send(16'h2104, b);
    chk(three_wire, "R11 three_wire flag", three_wire, 1);
    send(16'h10FE, b);
    h0 = oe_low;
    send(16'h0200, b);
    chk(oe_low - h0 >= 16, "R11 oe low in read-only", oe_low - h0, 16);
    push_tx(8'h69);
    h0 = oe_low;
    send(16'h0300, b);
    chk(oe_low == h0, "R11 oe high when sending", oe_low - h0, 0);
    send(16'h10FF, b);

    // R12 ignored writes and opcodes
    cur_mode = 3'd0;
    send(16'h2100, b);
    send(16'h2207, b);
    chk(three_wire == 1'b0 && sclk == 1'b0, "R12 bad register ignored", {three_wire, sclk}, 0);
    send(16'h7F00, b);
    @(negedge clk);
    chk(cs_n == 8'hFF && !sync_pulse && cmd_ready, "R12 bad opcode ignored", {cs_n, sync_pulse}, {8'hFF, 1'b0});

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule